// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins. The pins are grouped into banks of 32. Each bank has its own copy of seven registers: pin enable, output data, direction, input data, interrupt mask, event status and edge polarity. A simple word-wide register bus reads and writes these registers. Read data comes back one cycle after the request.

Each pin drives an output value and an output enable, and it samples an input value. Inputs pass through a two-stage synchroniser. A per-pin edge detector then sets a status bit on the selected polarity. One combined interrupt line rises while any pin holds a pending event whose mask bit is clear.

When the pin count is not a multiple of 32, the last bank is partly filled. Its unused bits act as plain storage and never produce events.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is disabled (enable 0) and configured as an input (direction 1). Every mask bit is 1, status, edge and output data are 0, `pin_oe` and `pin_out` are 0, and `irq` is low.
- R2: The byte address is formed as {register code, bank index, 2'b00}. The bank index is bits [2 +: BANK_W], and the register code is the 3 bits directly above it. With 40 pins BANK_W is 1, so the offset is code*8 + bank*4. The codes are: 0 enable, 1 output data, 2 direction, 3 input data, 4 mask, 5 status, 6 edge polarity. Code 7 reads 0. An access with address bits [1:0] not equal to 00 is ignored and reads 0. `bus_rdata` holds the read value in the cycle after the request.
- R3: `pin_oe[n]` is 1 exactly when enable[n] is 1 and direction[n] is 0. `pin_out[n]` equals output data[n] while `pin_oe[n]` is 1, and is 0 otherwise.
- R4: The input data register returns the synchronised `pin_in` value for enabled pins and 0 for disabled pins. Writes to it change nothing.
- R5: On an enabled pin, edge bit 1 selects a rising event and edge bit 0 selects a falling event. An event sets that pin's status bit whether or not the pin is masked. A disabled pin never sets status.
- R6: A write to status clears each bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a bit.
- R7: If an event and a clearing status write hit the same bit in the same cycle, the bit ends set.
- R8: `irq` is the OR over all pins of (status AND NOT mask). A mask bit of 1 blocks that pin.
- R9: In the partly filled last bank, the bits above the pin count keep written values as storage. They never set status or raise `irq`, and no pin exists for them to drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address (code, bank, 2'b00) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | NUM_PINS | Raw asynchronous pin inputs |
| pin_out | output | NUM_PINS | Pin output values |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq | output | 1 | Combined unmasked event interrupt |

## Verification
The edge logic is tried with a falling edge on a falling-selected pin, a falling edge on a rising-selected pin, and a rising edge on that same pin. Together these separate correct polarity selection from an any-edge or an inverted detector. A toggle on a disabled pin shows that the enable gates event capture. Masked and unmasked pending bits are compared on `irq`, which catches a mask read with the wrong sense. A clearing write placed in the exact cycle an event is detected tells whether the event or the clear takes priority. The partly filled second bank is driven with all-ones writes to show that storage bits do not leak into status or interrupts.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int BANK_BITS = 32;

    typedef enum logic [2:0] {
        REG_EN    = 3'd0,
        REG_WDAT  = 3'd1,
        REG_DIR   = 3'd2,
        REG_RDAT  = 3'd3,
        REG_MASK  = 3'd4,
        REG_STAT  = 3'd5,
        REG_EDGE  = 3'd6,
        REG_SPARE = 3'd7
    } gpio_reg_e;

    typedef struct packed {
        logic [BANK_BITS-1:0] en;
        logic [BANK_BITS-1:0] wdat;
        logic [BANK_BITS-1:0] dir;
        logic [BANK_BITS-1:0] mask;
        logic [BANK_BITS-1:0] stat;
        logic [BANK_BITS-1:0] rise;
    } bank_state_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = raw_i;
        s_d.cur  = s_q.meta;
        s_d.prev = s_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_o  = s_q.cur;
    assign prev_o = s_q.prev;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_ctrl_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  gpio_reg_e       wr_reg,
    input  logic [31:0]     wr_data,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    output bank_state_t     view_o,
    output logic [31:0]     rdata_o,
    output logic            irq_o
);
    localparam logic [31:0] VMASK = (PINS >= 32) ? '1 : ((32'd1 << PINS) - 32'd1);

    bank_state_t     s_d, s_q;
    logic [PINS-1:0] cur, prev;
    logic [PINS-1:0] rise_e, fall_e;
    logic [31:0]     evt;

    gpio_sync #(.W(PINS)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .cur_o  (cur),
        .prev_o (prev)
    );

    always_comb begin
        rise_e = cur & ~prev;
        fall_e = ~cur & prev;
        evt    = 32'((rise_e & s_q.rise[PINS-1:0]) | (fall_e & ~s_q.rise[PINS-1:0]))
                 & 32'(s_q.en[PINS-1:0]);

        s_d = s_q;
        if (wr_en) begin
            case (wr_reg)
                REG_EN:   s_d.en   = wr_data;
                REG_WDAT: s_d.wdat = wr_data;
                REG_DIR:  s_d.dir  = wr_data;
                REG_MASK: s_d.mask = wr_data;
                REG_EDGE: s_d.rise = wr_data;
                REG_STAT: s_d.stat = s_q.stat & wr_data;
                default:  ;
            endcase
        end
        s_d.stat = s_d.stat | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.dir  <= '1;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign pin_oe  = s_q.en[PINS-1:0] & ~s_q.dir[PINS-1:0];
    assign pin_out = s_q.wdat[PINS-1:0] & pin_oe;
    assign rdata_o = 32'(cur & s_q.en[PINS-1:0]);
    assign irq_o   = |(s_q.stat & ~s_q.mask);
    assign view_o  = s_q;

    // R3: a pin set as input is never driven
    p_input_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & s_q.dir[PINS-1:0]) == '0);

    // R4: a write to the input data register leaves configuration untouched
    p_rdat_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg == REG_RDAT) |=>
            ($stable(s_q.en) && $stable(s_q.wdat) && $stable(s_q.dir)
             && $stable(s_q.mask) && $stable(s_q.rise)));

    // R5: a detected event is recorded in status one cycle later
    p_event_sets_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((s_q.stat & $past(evt)) == $past(evt)));

    // R6: a status write without events yields the AND of old and written bits
    p_stat_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg == REG_STAT && evt == '0) |=>
            (s_q.stat == ($past(s_q.stat) & $past(wr_data))));

    // R7: an event beats a clearing write in the same cycle
    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg == REG_STAT && (|evt)) |=>
            ((s_q.stat & $past(evt)) == $past(evt)));

    // R9: bits beyond the pin count never hold status
    p_ghost_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stat & ~VMASK) == '0);

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter  int NUM_PINS  = 40,
    localparam int NUM_BANKS = (NUM_PINS + BANK_BITS - 1) / BANK_BITS,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W    = 2 + BANK_W + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int SLOTS = 1 << BANK_W;

    typedef struct packed {
        logic [31:0] rdata;
    } top_state_t;

    top_state_t          t_d, t_q;
    logic                aligned;
    logic [BANK_W-1:0]   bank_idx;
    gpio_reg_e           reg_sel;
    bank_state_t         views [SLOTS];
    logic [31:0]         rdats [SLOTS];
    logic [NUM_BANKS-1:0] bank_irq;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign bank_idx = bus_addr[2 +: BANK_W];
    assign reg_sel  = gpio_reg_e'(bus_addr[2 + BANK_W +: 3]);

    for (genvar b = 0; b < SLOTS; b++) begin : g_bank
        if (b < NUM_BANKS) begin : g_real
            localparam int PINS = (b == NUM_BANKS - 1) ? (NUM_PINS - b * BANK_BITS) : BANK_BITS;
            gpio_bank #(.PINS(PINS)) i_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (bus_sel && bus_we && aligned && (bank_idx == BANK_W'(b))),
                .wr_reg  (reg_sel),
                .wr_data (bus_wdata),
                .pin_in  (pin_in[b * BANK_BITS +: PINS]),
                .pin_out (pin_out[b * BANK_BITS +: PINS]),
                .pin_oe  (pin_oe[b * BANK_BITS +: PINS]),
                .view_o  (views[b]),
                .rdata_o (rdats[b]),
                .irq_o   (bank_irq[b])
            );
        end else begin : g_empty
            assign views[b] = '0;
            assign rdats[b] = '0;
        end
    end

    always_comb begin
        t_d = t_q;
        if (bus_sel && !bus_we) begin
            t_d.rdata = '0;
            if (aligned) begin
                case (reg_sel)
                    REG_EN:   t_d.rdata = views[bank_idx].en;
                    REG_WDAT: t_d.rdata = views[bank_idx].wdat;
                    REG_DIR:  t_d.rdata = views[bank_idx].dir;
                    REG_RDAT: t_d.rdata = rdats[bank_idx];
                    REG_MASK: t_d.rdata = views[bank_idx].mask;
                    REG_STAT: t_d.rdata = views[bank_idx].stat;
                    REG_EDGE: t_d.rdata = views[bank_idx].rise;
                    default:  t_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bus_rdata = t_q.rdata;
    assign irq       = |bank_irq;

    // R2: a misaligned read returns zero on the following cycle
    p_misaligned_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && !aligned) |=> (bus_rdata == '0));

    // R2: the spare register code reads as zero
    p_spare_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && reg_sel == REG_SPARE) |=> (bus_rdata == '0));

endmodule

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;
    localparam int NP = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = 40'h0F_0000_0133;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    bit pend   = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP)) i_gpio_bank_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // register codes (R2)
    localparam int C_EN = 0, C_WD = 1, C_DIR = 2, C_RD = 3, C_MSK = 4, C_ST = 5, C_EDG = 6, C_SP = 7;

    function automatic logic [5:0] a(int code, int bank);
        return 6'(code * 8 + bank * 4);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr_raw(logic [5:0] ad, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ad; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(int code, int bank, logic [31:0] d);
        wr_raw(a(code, bank), d);
    endtask

    task automatic rd_raw(logic [5:0] ad, logic [31:0] expv, string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ad;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd(int code, int bank, logic [31:0] expv, string tag);
        rd_raw(a(code, bank), expv, tag);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: a read accepted at a rising edge is compared at the next falling edge
    always @(posedge clk) pend <= rst_n && bus_sel && !bus_we;

    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, 64'(bus_rdata), 64'(e));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check("R1 pin_oe", 64'(pin_oe), 64'h0);
        check("R1 pin_out", 64'(pin_out), 64'h0);
        check("R1 irq", 64'(irq), 64'h0);
        rd(C_EN, 0, 32'h0, "R1 enable");
        rd(C_DIR, 0, 32'hFFFF_FFFF, "R1 direction");
        rd(C_MSK, 1, 32'hFFFF_FFFF, "R1 mask");
        rd(C_ST, 0, 32'h0, "R1 status");
        rd(C_WD, 1, 32'h0, "R1 output data");

        // R3 output drive
        wr(C_EN, 0, 32'h0000_00FF);
        wr(C_DIR, 0, 32'hFFFF_FF0F);
        wr(C_WD, 0, 32'h0000_00A5);
        check("R3 pin_oe", 64'(pin_oe), 64'h00_0000_00F0);
        check("R3 pin_out", 64'(pin_out), 64'h00_0000_00A0);

        // R4 input data
        wr(C_EN, 1, 32'h0000_000F);
        idle(3);
        rd(C_RD, 0, 32'h0000_0033, "R4 input data bank0");
        rd(C_RD, 1, 32'h0000_000F, "R4 input data bank1");
        wr(C_RD, 0, 32'h0000_0000);
        rd(C_RD, 0, 32'h0000_0033, "R4 write to input data ignored");
        rd(C_EN, 0, 32'h0000_00FF, "R4 enable untouched");
        rd(C_WD, 0, 32'h0000_00A5, "R4 output data untouched");
        check("R4 pins untouched", 64'(pin_oe), 64'h00_0000_00F0);

        // R2 map details
        wr_raw(a(C_EN, 0) | 6'd1, 32'h0);
        rd(C_EN, 0, 32'h0000_00FF, "R2 misaligned write ignored");
        rd_raw(a(C_EN, 0) | 6'd2, 32'h0, "R2 misaligned read");
        rd(C_SP, 0, 32'h0, "R2 spare code");
        wr(C_EDG, 0, 32'h0000_0001);
        rd(C_EDG, 0, 32'h0000_0001, "R2 edge register offset");
        rd(C_EDG, 1, 32'h0, "R2 bank separation");

        // R5 edge polarity and enable gating
        wr(C_ST, 0, 32'h0);
        wr(C_ST, 1, 32'h0);
        rd(C_ST, 0, 32'h0, "R5 status clean");
        @(negedge clk) pin_in[1] = 1'b0;
        idle(4);
        rd(C_ST, 0, 32'h2, "R5 falling edge on falling pin");
        @(negedge clk) pin_in[0] = 1'b0;
        idle(4);
        rd(C_ST, 0, 32'h2, "R5 falling edge on rising pin ignored");
        @(negedge clk) pin_in[0] = 1'b1;
        idle(4);
        rd(C_ST, 0, 32'h3, "R5 rising edge on rising pin");
        check("R8 masked pending no irq", 64'(irq), 64'h0);
        @(negedge clk) pin_in[8] = 1'b0;
        idle(4);
        rd(C_ST, 0, 32'h3, "R5 disabled pin no event");

        // R8 and R6
        wr(C_MSK, 0, 32'hFFFF_FFFD);
        check("R8 unmasked pending irq", 64'(irq), 64'h1);
        wr(C_ST, 0, 32'hFFFF_FFFD);
        rd(C_ST, 0, 32'h1, "R6 zero clears bit");
        check("R8 irq after clear", 64'(irq), 64'h0);
        wr(C_MSK, 0, 32'hFFFF_FFFC);
        check("R8 second pin unmasked", 64'(irq), 64'h1);
        wr(C_ST, 0, 32'hFFFF_FFFF);
        rd(C_ST, 0, 32'h1, "R6 one keeps bit");
        wr(C_ST, 0, 32'h0);
        rd(C_ST, 0, 32'h0, "R6 full clear");
        check("R8 irq idle", 64'(irq), 64'h0);

        // R7 collision of event and clear
        @(negedge clk) pin_in[1] = 1'b1;
        idle(4);
        rd(C_ST, 0, 32'h0, "R7 precondition rise on falling pin");
        @(negedge clk) pin_in[1] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a(C_ST, 0); bus_wdata = 32'h0;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        rd(C_ST, 0, 32'h2, "R7 event wins over clear");
        check("R7 irq after collision", 64'(irq), 64'h1);
        wr(C_ST, 0, 32'h0);
        wr(C_MSK, 0, 32'hFFFF_FFFF);

        // R9 partly filled bank
        wr(C_EN, 1, 32'hFFFF_FFFF);
        wr(C_DIR, 1, 32'h0);
        wr(C_WD, 1, 32'hFFFF_FFFF);
        check("R9 pin_oe", 64'(pin_oe), 64'hFF_0000_00F0);
        check("R9 pin_out", 64'(pin_out), 64'hFF_0000_00A0);
        rd(C_EN, 1, 32'hFFFF_FFFF, "R9 storage bits kept");
        wr(C_EDG, 1, 32'hFFFF_FFFF);
        wr(C_MSK, 1, 32'h0);
        wr(C_ST, 1, 32'h0);
        check("R9 irq before events", 64'(irq), 64'h0);
        @(negedge clk) pin_in[39:32] = 8'hFF;
        idle(4);
        rd(C_ST, 1, 32'h0000_00F0, "R9 status only in real pins");
        check("R9 irq from real pins", 64'(irq), 64'h1);
        wr(C_ST, 1, 32'hFFFF_FFFF);
        rd(C_ST, 1, 32'h0000_00F0, "R9 write cannot set upper status");
        wr(C_ST, 1, 32'h0);
        check("R9 irq after clear", 64'(irq), 64'h0);

        idle(3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule